// File: doc/BRIEF.md
# Integer ALU for a Load-Store Register Machine

This block is the arithmetic and logic unit of a three-operand register machine. Two 32-bit source operands come in, along with a 5-bit shift count, a 16-bit immediate, a four-bit operation code and a flag that selects the immediate in place of the second source. The block returns a 32-bit result and a flag that is high when that result is zero. Branch logic compares two registers by issuing a subtract and testing this flag for equal or not-equal.

When the immediate is selected, a small pre-stage widens it to 32 bits. Arithmetic and compare operations sign-extend it. Bitwise operations zero-extend it. The load-upper operation uses the immediate directly and ignores the second source. A build parameter places a register on the outputs, which gives a one-cycle latency. With that parameter cleared, the block is purely combinational.

Top module: `alu_core`

## Requirements
- R1: Operation codes: 0 add, 1 subtract, 2 AND, 3 OR, 4 NOR, 5 signed less-than, 6 unsigned less-than, 7 shift left, 8 shift right, 9 load-upper. Add gives A+B and subtract gives A-B, both modulo 2^32 with no exception.
- R2: AND and OR return the bitwise AND and OR of A and the second operand.
- R3: NOR returns ~(A | B), so NOR with a zero B returns the complement of A.
- R4: Signed less-than returns 1 when A < B as two's complement, and unsigned less-than does the same for unsigned values. Otherwise each returns 0, and bits 31:1 are always 0. For A=0xFFFFFFFF and B=0x00000001 the signed form gives 1 and the unsigned form gives 0.
- R5: Shift left and shift right move src_a by shamt (0 to 31) positions and fill the vacated bits with zeros.
- R6: Load-upper returns imm in bits 31:16 and zeros in bits 15:0, and it ignores src_b and use_imm. An OR with imm as the operand can then set the low half.
- R7: With use_imm=1, add, subtract, signed less-than and unsigned less-than use imm sign-extended from bit 15 as B.
- R8: With use_imm=1, AND, OR and NOR use imm zero-extended as B.
- R9: zero is 1 exactly when the 32-bit result is 0.
- R10: Operation codes 10 to 15 give a result of 0, so zero is 1.
- R11: With OUT_REG=1 (the default), the outputs reflect the inputs present at the previous rising clock edge. While rst_n is low, result is 0 and zero is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 4 | Operation code |
| use_imm | input | 1 | Use the extended immediate as the second operand |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| shamt | input | 5 | Shift count |
| imm | input | 16 | Immediate field |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is zero |

## Verification
Random operands are paired with random operation codes, including the unused ones, and with both settings of use_imm. This separates each result path and the two extension rules. Directed cases cover the following:
- sign boundaries, where 0xFFFFFFFF against 1 splits the signed compare from the unsigned one;
- wrap-around in add and subtract;
- an immediate with bit 15 set, which splits sign extension from zero extension;
- shift counts of 0 and 31;
- NOR against zero;
- a load-upper followed by an OR with the immediate.

A check that the result is still unchanged just after new inputs are applied confirms the registered latency.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_NOR  = 4'd4,
        OP_SLT  = 4'd5,
        OP_SLTU = 4'd6,
        OP_SLL  = 4'd7,
        OP_SRL  = 4'd8,
        OP_LUI  = 4'd9
    } alu_op_e;

endpackage

// File: rtl/alu_imm_stage.sv
module alu_imm_stage
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [OP_W-1:0]   op_sel,
    input  logic              use_imm,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sx;
    logic [DATA_W-1:0] imm_zx;
    logic              want_sign;

    always_comb begin
        imm_sx = {{PAD_W{imm[IMM_W-1]}}, imm};
        imm_zx = {{PAD_W{1'b0}}, imm};
        want_sign = (op_sel == OP_ADD) || (op_sel == OP_SUB) ||
                    (op_sel == OP_SLT) || (op_sel == OP_SLTU);
        if (!use_imm) begin
            opnd_b = src_b;
        end else if (want_sign) begin
            opnd_b = imm_sx;
        end else begin
            opnd_b = imm_zx;
        end
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              do_sub,
    output logic [DATA_W-1:0] sum,
    output logic              lt_signed,
    output logic              lt_unsigned
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0]   wide_d;
    logic [DATA_W-1:0] b_inv;

    always_comb begin
        b_inv  = do_sub ? ~opnd_b : opnd_b;
        wide_d = {1'b0, opnd_a} + {1'b0, b_inv} + {{DATA_W{1'b0}}, do_sub};
        sum    = wide_d[DATA_W-1:0];
        // For a subtract, a clear carry-out means a borrow, so A < B unsigned.
        lt_unsigned = ~wide_d[DATA_W];
        lt_signed   = (opnd_a[MSB] ^ opnd_b[MSB]) ? opnd_a[MSB] : wide_d[MSB];
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = 5
) (
    input  logic [DATA_W-1:0]  din,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [DATA_W-1:0]  left_out,
    output logic [DATA_W-1:0]  right_out
);
    logic [DATA_W-1:0] lstage [SHAMT_W+1];
    logic [DATA_W-1:0] rstage [SHAMT_W+1];

    assign lstage[0] = din;
    assign rstage[0] = din;

    for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
        localparam int STEP = 1 << i;
        assign lstage[i+1] = shamt[i] ? (lstage[i] << STEP) : lstage[i];
        assign rstage[i+1] = shamt[i] ? (rstage[i] >> STEP) : rstage[i];
    end

    assign left_out  = lstage[SHAMT_W];
    assign right_out = rstage[SHAMT_W];
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 16,
    parameter int SHAMT_W = $clog2(DATA_W),
    parameter bit OUT_REG = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    op_sel,
    input  logic               use_imm,
    input  logic [DATA_W-1:0]  src_a,
    input  logic [DATA_W-1:0]  src_b,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [IMM_W-1:0]   imm,
    output logic [DATA_W-1:0]  result,
    output logic               zero
);
    localparam int LOW_W = DATA_W - IMM_W;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              zf;
    } alu_out_t;

    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] sum;
    logic              lt_s;
    logic              lt_u;
    logic [DATA_W-1:0] shl;
    logic [DATA_W-1:0] shr;
    alu_out_t          out_d;
    alu_out_t          out_q;

    alu_imm_stage #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_imm (
        .op_sel (op_sel),
        .use_imm(use_imm),
        .imm    (imm),
        .src_b  (src_b),
        .opnd_b (opnd_b)
    );

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .opnd_a     (src_a),
        .opnd_b     (opnd_b),
        .do_sub     (op_sel != OP_ADD),
        .sum        (sum),
        .lt_signed  (lt_s),
        .lt_unsigned(lt_u)
    );

    alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
        .din      (src_a),
        .shamt    (shamt),
        .left_out (shl),
        .right_out(shr)
    );

    always_comb begin
        out_d = '0;
        case (op_sel)
            OP_ADD,
            OP_SUB:  out_d.res = sum;
            OP_AND:  out_d.res = src_a & opnd_b;
            OP_OR:   out_d.res = src_a | opnd_b;
            OP_NOR:  out_d.res = ~(src_a | opnd_b);
            OP_SLT:  out_d.res = {{(DATA_W-1){1'b0}}, lt_s};
            OP_SLTU: out_d.res = {{(DATA_W-1){1'b0}}, lt_u};
            OP_SLL:  out_d.res = shl;
            OP_SRL:  out_d.res = shr;
            OP_LUI:  out_d.res = {imm, {LOW_W{1'b0}}};
            default: out_d.res = '0;
        endcase
        out_d.zf = (out_d.res == '0);
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_q <= '{res: '0, zf: 1'b1};
            end else begin
                out_q <= out_d;
            end
        end
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign result = out_q.res;
    assign zero   = out_q.zf;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
    import alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 16,
    parameter int SHAMT_W = 5,
    parameter bit OUT_REG = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [OP_W-1:0]    op_sel,
    input logic               use_imm,
    input logic [DATA_W-1:0]  src_a,
    input logic [DATA_W-1:0]  src_b,
    input logic [SHAMT_W-1:0] shamt,
    input logic [IMM_W-1:0]   imm,
    input logic [DATA_W-1:0]  result,
    input logic               zero
);
    localparam int LOW_W = DATA_W - IMM_W;

    logic [OP_W-1:0]    op_seen;
    logic               ui_seen;
    logic [DATA_W-1:0]  a_seen;
    logic [DATA_W-1:0]  b_seen;
    logic [SHAMT_W-1:0] sh_seen;
    logic [IMM_W-1:0]   imm_seen;
    logic               valid;

    if (OUT_REG) begin : g_lat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid    <= 1'b0;
                op_seen  <= '0;
                ui_seen  <= 1'b0;
                a_seen   <= '0;
                b_seen   <= '0;
                sh_seen  <= '0;
                imm_seen <= '0;
            end else begin
                valid    <= 1'b1;
                op_seen  <= op_sel;
                ui_seen  <= use_imm;
                a_seen   <= src_a;
                b_seen   <= src_b;
                sh_seen  <= shamt;
                imm_seen <= imm;
            end
        end
    end else begin : g_now
        assign valid    = 1'b1;
        assign op_seen  = op_sel;
        assign ui_seen  = use_imm;
        assign a_seen   = src_a;
        assign b_seen   = src_b;
        assign sh_seen  = shamt;
        assign imm_seen = imm;
    end

    logic [DATA_W-1:0] low_mask;
    logic [DATA_W-1:0] high_mask;
    assign low_mask  = (DATA_W'(1) << sh_seen) - DATA_W'(1);
    assign high_mask = ~({DATA_W{1'b1}} >> sh_seen);

    p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (zero == (result == '0)));

    p_slt_binary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (op_seen == OP_SLT || op_seen == OP_SLTU)) |-> (result[DATA_W-1:1] == '0));

    p_lui_place_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op_seen == OP_LUI) |-> (result == {imm_seen, {LOW_W{1'b0}}}));

    p_unknown_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op_seen > OP_LUI) |-> (result == '0 && zero));

    p_nor_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op_seen == OP_NOR && !ui_seen) |-> (result == ~(a_seen | b_seen)));

    p_sll_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op_seen == OP_SLL) |-> ((result & low_mask) == '0));

    p_srl_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op_seen == OP_SRL) |-> ((result & high_mask) == '0));
endmodule

bind alu_core alu_core_chk #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .SHAMT_W(SHAMT_W),
    .OUT_REG(OUT_REG)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_sel (op_sel),
    .use_imm(use_imm),
    .src_a  (src_a),
    .src_b  (src_b),
    .shamt  (shamt),
    .imm    (imm),
    .result (result),
    .zero   (zero)
);

// File: tb/alu_core_test.sv
`timescale 1ns/1ps
module alu_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = '0;
    logic        use_imm = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [4:0]  shamt = '0;
    logic [15:0] imm = '0;
    logic [31:0] result;
    logic        zero;

    int total = 0;
    int bad = 0;
    logic [31:0] prev_exp = 32'h0;

    always #4 clk = ~clk;

    alu_core uut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .use_imm(use_imm),
        .src_a(src_a), .src_b(src_b), .shamt(shamt), .imm(imm),
        .result(result), .zero(zero)
    );

    function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [4:0] sh,
                                          input logic [15:0] im, input logic ui);
        logic [31:0] bb;
        bb = b;
        if (ui) bb = (op <= 4'd1 || op == 4'd5 || op == 4'd6) ?
                     {{16{im[15]}}, im} : {16'h0, im};
        case (op)
            4'd0: return a + bb;
            4'd1: return a - bb;
            4'd2: return a & bb;
            4'd3: return a | bb;
            4'd4: return ~(a | bb);
            4'd5: return ($signed(a) < $signed(bb)) ? 32'd1 : 32'd0;
            4'd6: return (a < bb) ? 32'd1 : 32'd0;
            4'd7: return a << sh;
            4'd8: return a >> sh;
            4'd9: return {im, 16'h0};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic ui);
        if (op > 4'd9) return "R10";
        if (op == 4'd9) return "R6";
        if (op == 4'd7 || op == 4'd8) return "R5";
        if (ui && (op <= 4'd1 || op == 4'd5 || op == 4'd6)) return "R7";
        if (ui) return "R8";
        if (op <= 4'd1) return "R1";
        if (op == 4'd4) return "R3";
        if (op <= 4'd3) return "R2";
        return "R4";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] sh, input logic [15:0] im, input logic ui);
        logic [31:0] e;
        @(negedge clk);
        op_sel = op; src_a = a; src_b = b; shamt = sh; imm = im; use_imm = ui;
        #1;
        check("R11 hold", result, prev_exp);
        e = model(op, a, b, sh, im, ui);
        @(negedge clk);
        check(tag_of(op, ui), result, e);
        check("R9", {31'h0, zero}, {31'h0, (e == 32'h0)});
        prev_exp = e;
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] hi;
        void'($urandom(32'd4242));
        src_a = 32'hDEAD_BEEF; src_b = 32'h1; op_sel = 4'd0;
        repeat (2) @(negedge clk);
        check("R11 reset result", result, 32'h0);
        check("R11 reset zero", {31'h0, zero}, 32'h1);
        @(negedge clk);
        rst_n = 1'b1;
        op_sel = '0; src_a = '0; src_b = '0;
        // directed corner cases
        apply(4'd5, 32'hFFFF_FFFF, 32'h1, 5'd0, 16'h0, 1'b0);   // R4 signed -1 < 1
        apply(4'd6, 32'hFFFF_FFFF, 32'h1, 5'd0, 16'h0, 1'b0);   // R4 unsigned
        apply(4'd0, 32'hFFFF_FFFF, 32'h1, 5'd0, 16'h0, 1'b0);   // R1 wrap to 0
        apply(4'd1, 32'h0, 32'h1, 5'd0, 16'h0, 1'b0);           // R1 wrap below 0
        apply(4'd1, 32'h1234_5678, 32'h1234_5678, 5'd0, 16'h0, 1'b0); // R9 equal
        apply(4'd4, 32'h0000_3C00, 32'h0, 5'd0, 16'h0, 1'b0);   // R3 NOT via NOR
        apply(4'd0, 32'h10, 32'h0, 5'd0, 16'hFFFF, 1'b1);        // R7 add -1
        apply(4'd5, 32'h0, 32'h0, 5'd0, 16'h8000, 1'b1);         // R7 slt vs negative
        apply(4'd2, 32'hFFFF_FFFF, 32'h0, 5'd0, 16'h8000, 1'b1); // R8 zero-extend
        apply(4'd3, 32'h0, 32'hFFFF_FFFF, 5'd0, 16'h8001, 1'b1); // R8 OR imm
        apply(4'd7, 32'h8000_0001, 32'h0, 5'd31, 16'h0, 1'b0);  // R5 shift 31
        apply(4'd8, 32'h8000_0001, 32'h0, 5'd31, 16'h0, 1'b0);  // R5 shift 31
        apply(4'd7, 32'hA5A5_A5A5, 32'h0, 5'd0, 16'h0, 1'b0);   // R5 shift 0
        apply(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3, 16'h1, 1'b0); // R10
        // R6 load-upper, then OR immediate builds a full constant
        apply(4'd9, 32'h1111_1111, 32'h2222_2222, 5'd0, 16'hAAAA, 1'b1);
        hi = prev_exp;
        apply(4'd3, hi, 32'h0, 5'd0, 16'h5555, 1'b1);
        check("R6 constant", result, 32'hAAAA_5555);
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom();
            rb = $urandom();
            case ($urandom() % 6)
                0: ra = 32'h8000_0000;
                1: rb = 32'h7FFF_FFFF;
                2: rb = ra;
                default: ;
            endcase
            apply(4'($urandom() % 16), ra, rb, 5'($urandom()), 16'($urandom()),
                  1'($urandom()));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule